// File: doc/BRIEF.md
# Staged Subsystem Reset Sequencer

This block brings a chain of subsystems out of reset one after another once the supply is stable. A single active-low master reset, produced by an external power-detect circuit, holds every subsystem reset low. When that master reset is released, the sequencer lets go of stage 0 first (the free-running ring oscillator, which only starts oscillating once released). It then waits for that stage to report completion before releasing the next stage. The order is fixed, so that each stage finds its dependencies already running. The memory stage completes before the processor complex, which is always the last stage and starts fetching from address 0x00000000 once released.

Completion inputs are asynchronous to the sequencer clock and each passes through a two-flop synchronizer. The master reset clears everything at once, asynchronously, and is released into the sequencer through its own two-flop synchronizer. A done flag marks the end of the chain. A stage index output shows which stage is currently pending, for debug.

The controller is one state machine with three states:
- `ST_HOLD`: all stages are in reset.
- `ST_PEND`: one stage is released and awaiting completion.
- `ST_DONE`: every stage is released.

Its transitions are:
- `HOLD_TO_PEND`: the synchronized reset is seen released. Stage 0 is let go.
- `PEND_ADVANCE`: the current stage completes and it is not the last one. The index steps up.
- `PEND_TO_DONE`: the last stage completes.
- `ANY_TO_HOLD`: the master reset goes low, asynchronously.

Top module: `seq_reset_ctrl`

## Requirements
- R1: While `mrst_n` is low, every bit of `stage_rst_n_o` is 0, `seq_done_o` is 0 and `cur_stage_o` is 0, and the outputs go to these values as soon as `mrst_n` falls, without waiting for a clock edge.
- R2: After `mrst_n` rises, all stage resets stay low for two rising clock edges, and stage 0 (bit 0 of `stage_rst_n_o`) goes high on the third rising edge.
- R3: Stages are released in ascending index order, at most one new stage per cycle. At any time, `stage_rst_n_o` has the form of ones in bits 0..k and zeros above.
- R4: With stage k pending, raising `stage_done_i[k]` (and holding it) releases stage k+1 on the third rising clock edge after the change, and not earlier.
- R5: A completion input of any stage other than the pending one has no effect on `stage_rst_n_o`, `cur_stage_o` or `seq_done_o`.
- R6: A released stage keeps its reset output high until `mrst_n` falls, even if its completion input later drops.
- R7: `seq_done_o` goes high on the third rising edge after `stage_done_i[N_STAGES-1]` is raised, with all stages released. It stays high, whatever the completion inputs do, until `mrst_n` falls.
- R8: `cur_stage_o` equals the index of the pending stage (the highest released bit) and holds `N_STAGES-1` once the sequence is done.
- R9: Taking `mrst_n` low in the middle of the sequence returns all outputs to low, and the next release of `mrst_n` restarts the chain from stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| mrst_n | input | 1 | Active-low master reset from power detect, asynchronous |
| stage_done_i | input | N_STAGES | Per-stage completion, asynchronous, high when done |
| stage_rst_n_o | output | N_STAGES | Per-stage active-low reset, high = released |
| seq_done_o | output | 1 | High once the whole chain has completed |
| cur_stage_o | output | IDX_W | Index of the pending stage (debug) |

## Verification
The assertions take for granted that a subsystem keeps its completion input high from the moment it reports done until the master reset is asserted. They also assume that completion inputs are low while the master reset is low. The check on the release of stage k+1 looks back three cycles at the completion of stage k, so it relies on that level being held. The stimulus follows these rules for the pending stage: it raises completion only after release, holds it for several cycles, and clears all completion inputs whenever it asserts the master reset. Short pulses on non-pending stages and drops of earlier completions are applied only where the rules above permit them, so the checks on order, persistence and the ignored inputs stay meaningful.

// File: rtl/seqrst_pkg.sv
package seqrst_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // every stage held in reset
        ST_PEND = 2'd1,   // one stage released, waiting for its completion
        ST_DONE = 2'd2    // whole chain released
    } seq_state_e;

    // Width of an index able to address n items (at least one bit)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seqrst_rst_sync.sv
// Reset synchronizer: asserts asynchronously, deasserts after DEPTH edges.
module seqrst_rst_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n
);

    logic [DEPTH-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[DEPTH-2:0], 1'b1};
        end
    end

    assign rst_n = chain_q[DEPTH-1];

endmodule

// File: rtl/seqrst_bit_sync.sv
// Multi-flop synchronizer, one independent chain per bit.
module seqrst_bit_sync #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] flop_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flop_q <= '0;
            end else begin
                flop_q <= {flop_q[DEPTH-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = flop_q[DEPTH-1];
    end

endmodule

// File: rtl/seqrst_fsm.sv
// Stage sequencing state machine.
module seqrst_fsm
    import seqrst_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] done_sync_i,
    output logic [N_STAGES-1:0] rel_n_o,
    output logic                seq_done_o,
    output logic [IDX_W-1:0]    cur_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_STAGES - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             cur_seen;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        cur_seen = done_sync_i[idx_q];
        unique case (state_q)
            ST_HOLD: begin
                // HOLD_TO_PEND
                state_d = ST_PEND;
                idx_d   = '0;
            end
            ST_PEND: begin
                if (cur_seen) begin
                    if (idx_q == LAST_IDX) begin
                        // PEND_TO_DONE
                        state_d = ST_DONE;
                    end else begin
                        // PEND_ADVANCE
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: begin
                state_d = ST_HOLD;
                idx_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        for (int i = 0; i < N_STAGES; i++) begin
            rel_n_o[i] = (state_q == ST_DONE) ||
                         ((state_q == ST_PEND) && (IDX_W'(i) <= idx_q));
        end
        seq_done_o = (state_q == ST_DONE);
        cur_idx_o  = idx_q;
    end

endmodule

// File: rtl/seq_reset_ctrl.sv
// Staged subsystem reset sequencer, top level.
module seq_reset_ctrl
    import seqrst_pkg::*;
#(
    parameter int N_STAGES   = 4,
    parameter int SYNC_DEPTH = 2,
    localparam int IDX_W     = idx_width(N_STAGES)
) (
    input  logic                clk,
    input  logic                mrst_n,
    input  logic [N_STAGES-1:0] stage_done_i,
    output logic [N_STAGES-1:0] stage_rst_n_o,
    output logic                seq_done_o,
    output logic [IDX_W-1:0]    cur_stage_o
);

    logic                rst_int_n;
    logic [N_STAGES-1:0] done_sync;

    seqrst_rst_sync #(
        .DEPTH (SYNC_DEPTH)
    ) rst_sync_i (
        .clk    (clk),
        .arst_n (mrst_n),
        .rst_n  (rst_int_n)
    );

    seqrst_bit_sync #(
        .WIDTH (N_STAGES),
        .DEPTH (SYNC_DEPTH)
    ) done_sync_i (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .async_i (stage_done_i),
        .sync_o  (done_sync)
    );

    seqrst_fsm #(
        .N_STAGES (N_STAGES),
        .IDX_W    (IDX_W)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_int_n),
        .done_sync_i (done_sync),
        .rel_n_o     (stage_rst_n_o),
        .seq_done_o  (seq_done_o),
        .cur_idx_o   (cur_stage_o)
    );

endmodule

// File: rtl/seq_reset_ctrl_chk.sv
// Property checker for the reset sequencer (default sync depth of 2).
module seq_reset_ctrl_chk #(
    parameter int N_STAGES = 4,
    parameter int IDX_W    = 2
) (
    input logic                clk,
    input logic                mrst_n,
    input logic [N_STAGES-1:0] stage_done_i,
    input logic [N_STAGES-1:0] stage_rst_n_o,
    input logic                seq_done_o,
    input logic [IDX_W-1:0]    cur_stage_o
);

    always @(posedge clk) begin
        if (!mrst_n) begin
            // R1
            all_low_in_reset_chk: assert (stage_rst_n_o == '0 && !seq_done_o && cur_stage_o == '0);
        end
    end

    // R3
    one_new_release_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        $onehot0(stage_rst_n_o & ~$past(stage_rst_n_o)));

    // R3
    ascending_order_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        ((stage_rst_n_o + 1'b1) & stage_rst_n_o) == '0);

    // R6
    stays_released_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (stage_rst_n_o & $past(stage_rst_n_o)) == $past(stage_rst_n_o));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        seq_done_o |=> seq_done_o);

    // R7
    done_all_released_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        seq_done_o |-> (&stage_rst_n_o));

    // R8
    done_idx_last_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        seq_done_o |-> (cur_stage_o == IDX_W'(N_STAGES - 1)));

    for (genvar i = 1; i < N_STAGES; i++) begin : g_adv
        // R4
        advance_after_done_chk: assert property (@(posedge clk) disable iff (!mrst_n)
            $rose(stage_rst_n_o[i]) |-> $past(stage_done_i[i-1], 3));
    end

endmodule

bind seq_reset_ctrl seq_reset_ctrl_chk #(
    .N_STAGES (N_STAGES),
    .IDX_W    (IDX_W)
) chk_i (
    .clk           (clk),
    .mrst_n        (mrst_n),
    .stage_done_i  (stage_done_i),
    .stage_rst_n_o (stage_rst_n_o),
    .seq_done_o    (seq_done_o),
    .cur_stage_o   (cur_stage_o)
);

// File: tb/seq_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module seq_reset_ctrl_tb_top;

    localparam int N   = 4;
    localparam int IW  = 2;
    localparam int LAT = 3;   // two sync flops plus the state register

    logic          clk = 1'b0;
    logic          mrst_n = 1'b1;
    logic [N-1:0]  done = '0;
    logic [N-1:0]  rst_n_o;
    logic          sdone;
    logic [IW-1:0] cur;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_reset_ctrl #(.N_STAGES(N)) dut_i (
        .clk           (clk),
        .mrst_n        (mrst_n),
        .stage_done_i  (done),
        .stage_rst_n_o (rst_n_o),
        .seq_done_o    (sdone),
        .cur_stage_o   (cur)
    );

    function automatic logic [N-1:0] thermo(input int k);
        return N'((1 << (k + 1)) - 1);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Assert master reset, then release it and check the start-up timing
    task automatic do_reset();
        mrst_n = 1'b0;
        done   = '0;
        #0.5;
        check("R1 stage resets low at once", int'(rst_n_o), 0);
        check("R1 done low", int'(sdone), 0);
        check("R1 index zero", int'(cur), 0);
        tick(3);
        check("R1 held low", int'(rst_n_o), 0);
        mrst_n = 1'b1;
        tick(LAT - 1);
        check("R2 still held two edges", int'(rst_n_o), 0);
        tick(1);
        check("R2 stage0 released third edge", int'(rst_n_o), 1);
        check("R8 index 0", int'(cur), 0);
    endtask

    // Run the chain; abort_at >= 0 asserts master reset while that stage waits
    task automatic run_seq(input int run, input int abort_at);
        for (int k = 0; k < N; k++) begin
            int d;
            d = 6 + ((k * 5 + run * 3) % 7);
            for (int j = 0; j < d; j++) begin
                tick(1);
                check("R3 thermometer mask", int'(rst_n_o), int'(thermo(k)));
                check("R8 pending index", int'(cur), k);
                check("R5 done low while pending", int'(sdone), 0);
                if (j == 0) begin
                    for (int f = k + 1; f < N; f++) done[f] = 1'b1;   // R5 stimulus
                end
                if (j == 1) begin
                    for (int f = k + 1; f < N; f++) done[f] = 1'b0;
                end
                if (j == 3 && k > 0) done[k-1] = 1'b0;                 // R6 stimulus
                if (abort_at == k && j == d / 2) begin
                    mrst_n = 1'b0;
                    done   = '0;
                    #0.5;
                    check("R9 mid reset mask low", int'(rst_n_o), 0);
                    check("R9 mid reset done low", int'(sdone), 0);
                    check("R9 mid reset index zero", int'(cur), 0);
                    return;
                end
            end
            done[k] = 1'b1;
            tick(LAT - 1);
            check("R4 no early advance", int'(rst_n_o), int'(thermo(k)));
            check("R7 no early done", int'(sdone), 0);
            tick(1);
            if (k < N - 1) begin
                check("R4 next stage released", int'(rst_n_o), int'(thermo(k + 1)));
                check("R8 index advanced", int'(cur), k + 1);
            end else begin
                check("R7 done raised", int'(sdone), 1);
                check("R7 all released", int'(rst_n_o), int'(thermo(N - 1)));
                check("R8 index last", int'(cur), N - 1);
            end
        end
        tick(5);
        done = '0;
        tick(6);
        check("R7 done sticky", int'(sdone), 1);
        check("R6 all stay released", int'(rst_n_o), int'(thermo(N - 1)));
        done = '1;
        tick(4);
        check("R5 late inputs ignored", int'(rst_n_o), int'(thermo(N - 1)));
        check("R8 index stays last", int'(cur), N - 1);
    endtask

    initial begin
        #1 mrst_n = 1'b0;
        tick(2);
        for (int r = 0; r < 3; r++) begin
            do_reset();
            run_seq(r, -1);
        end
        for (int a = 0; a < N; a++) begin
            do_reset();
            run_seq(a + 3, a);
        end
        do_reset();   // R9 restart from stage 0 checked inside
        run_seq(9, -1);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule